// File: doc/BRIEF.md
# Arm Switch-Function Evaluator

This block models one converter arm built from a chain of half-bridge submodules inside a real-time simulation step. For each submodule it works out which ideal switch conducts. A gate command selects the switch directly. When both gates are off, the anti-parallel diodes are emulated and the sign of the arm current picks the conducting path. From those states the block forms each submodule's output voltage and capacitor current. It then combines the inserted voltages with the DC source voltage into the arm node voltage. Inserted voltages are subtracted for an upper arm and added for a lower arm.

The evaluation is a single combinational pass. Its results are captured on the clock edge at which the step strobe is high, so the block adds one register stage per simulation step. The capacitor-voltage and inductor integrators sit outside and feed the block's inputs. All quantities are signed fixed-point integers. The submodule count and the data width are parameters.

Top module: `arm_switch_eval`

## Requirements
- R1: A gate pair with the S1 gate high and the S2 gate low (pair value 2'b01, bit 0 = S1 gate, bit 1 = S2 gate, pair j at gate bits [2j+1:2j]) turns S1 on and S2 off, whatever the sign of the arm current.
- R2: A gate pair value 2'b10 turns S2 on and S1 off, whatever the sign of the arm current.
- R3: A gate pair value 2'b00 (dead time) gives S1 on when the arm current is zero or positive, and S2 on when it is negative.
- R4: A gate pair value 2'b11 sets that submodule's fault bit and is resolved exactly as 2'b00. No other pair value sets the fault bit.
- R5: Each submodule's capacitor current equals the arm current when its S1 is on and zero otherwise. Each submodule contributes its capacitor voltage to the sum only when its S1 is on.
- R6: With the lower-arm select at 0, the node voltage is the DC source voltage minus the sum of inserted submodule voltages, computed without overflow.
- R7: With the lower-arm select at 1, the node voltage is the DC source voltage plus that sum.
- R8: Outputs take new values only on the clock edge at which the step strobe is high, and hold at all other edges even when inputs change.
- R9: Synchronous reset clears every output to zero.
- R10: After the first step, exactly one of S1 and S2 is on in every submodule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Step strobe, captures the evaluation |
| arm_lower | input | 1 | 1 = lower arm, 0 = upper arm |
| i_arm | input | DW | Arm inductor current, signed |
| vdc | input | DW | DC source voltage, signed |
| vcap | input | N_SM*DW | Capacitor voltages, submodule j at [j*DW +: DW] |
| gate | input | 2*N_SM | Gate pairs, submodule j at [2j+1:2j] |
| s1_q | output | N_SM | Registered S1 states |
| s2_q | output | N_SM | Registered S2 states |
| fault_q | output | N_SM | Registered shoot-through flags |
| vnode_q | output | DW+clog2(N_SM)+1 | Registered arm node voltage, signed |
| icap_q | output | N_SM*DW | Registered capacitor currents, submodule j at [j*DW +: DW] |

## Verification
The bench drives zero arm current with blocked gates. A design that tests the sign with a strict greater-than would turn S2 on at zero current. Forced gate pairs are applied against a current of the opposite sign, which exposes any path that lets the current override a gate command. Shoot-through pairs are checked for both the flag and the blocked resolution, so a design that forced one switch on, or that dropped the flag, fails. Full-scale capacitor voltages on both arm polarities expose a narrow sum that wraps or a sign that is swapped between upper and lower arms. Idle cycles with changed inputs catch outputs that follow the combinational path.

// File: rtl/arm_eval_pkg.sv
package arm_eval_pkg;

  // Gate pair: bit 0 drives S1, bit 1 drives S2
  typedef enum logic [1:0] {
    GATE_BLOCK = 2'b00,
    GATE_S1    = 2'b01,
    GATE_S2    = 2'b10,
    GATE_SHOOT = 2'b11
  } gate_pair_e;

  typedef struct packed {
    logic s1;
    logic s2;
    logic fault;
  } sw_state_t;

  // Resolve conduction from the command and the input-current sign
  function automatic sw_state_t resolve_switch(gate_pair_e g, logic cur_neg);
    sw_state_t r;
    r.fault = 1'b0;
    unique case (g)
      GATE_S1: begin r.s1 = 1'b1; r.s2 = 1'b0; end
      GATE_S2: begin r.s1 = 1'b0; r.s2 = 1'b1; end
      GATE_SHOOT: begin
        r.fault = 1'b1;
        r.s1    = ~cur_neg;
        r.s2    = cur_neg;
      end
      default: begin r.s1 = ~cur_neg; r.s2 = cur_neg; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sm_switch_cell.sv
module sm_switch_cell
  import arm_eval_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]           gate_pair,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] vc,
  output logic                 s1,
  output logic                 s2,
  output logic                 fault,
  output logic signed [DW-1:0] vout,
  output logic signed [DW-1:0] icap
);

  sw_state_t st;

  always_comb begin
    st    = resolve_switch(gate_pair_e'(gate_pair), i_in[DW-1]);
    s1    = st.s1;
    s2    = st.s2;
    fault = st.fault;
    vout  = st.s1 ? vc : '0;
    icap  = st.s1 ? i_in : '0;
  end

endmodule

// File: rtl/arm_voltage_sum.sv
module arm_voltage_sum #(
  parameter int N_SM = 4,
  parameter int DW   = 16,
  localparam int SW  = DW + $clog2(N_SM) + 1
) (
  input  logic [N_SM*DW-1:0]   vout_flat,
  input  logic signed [DW-1:0] vdc,
  input  logic                 is_lower,
  output logic signed [SW-1:0] vnode
);

  logic signed [SW-1:0] partial [N_SM+1];

  assign partial[0] = '0;

  for (genvar k = 0; k < N_SM; k++) begin : g_acc
    logic signed [DW-1:0] term;
    assign term         = vout_flat[k*DW +: DW];
    assign partial[k+1] = partial[k] + SW'(term);
  end

  always_comb begin
    if (is_lower) vnode = SW'(vdc) + partial[N_SM];
    else          vnode = SW'(vdc) - partial[N_SM];
  end

endmodule

// File: rtl/arm_switch_eval.sv
module arm_switch_eval #(
  parameter int N_SM = 4,
  parameter int DW   = 16,
  localparam int SW  = DW + $clog2(N_SM) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 arm_lower,
  input  logic signed [DW-1:0] i_arm,
  input  logic signed [DW-1:0] vdc,
  input  logic [N_SM*DW-1:0]   vcap,
  input  logic [2*N_SM-1:0]    gate,
  output logic [N_SM-1:0]      s1_q,
  output logic [N_SM-1:0]      s2_q,
  output logic [N_SM-1:0]      fault_q,
  output logic signed [SW-1:0] vnode_q,
  output logic [N_SM*DW-1:0]   icap_q
);

  logic [N_SM-1:0]      s1_c, s2_c, fault_c;
  logic [N_SM*DW-1:0]   vout_c, icap_c;
  logic signed [DW-1:0] cur [N_SM];
  logic signed [SW-1:0] vnode_c;

  // Current entering submodule 0 is the arm current
  assign cur[0] = i_arm;

  for (genvar j = 0; j < N_SM; j++) begin : g_sm
    sm_switch_cell #(.DW(DW)) u_cell (
      .gate_pair (gate[2*j +: 2]),
      .i_in      (cur[j]),
      .vc        (vcap[j*DW +: DW]),
      .s1        (s1_c[j]),
      .s2        (s2_c[j]),
      .fault     (fault_c[j]),
      .vout      (vout_c[j*DW +: DW]),
      .icap      (icap_c[j*DW +: DW])
    );
    // Output current of one stage feeds the next stage
    if (j + 1 < N_SM) begin : g_link
      assign cur[j+1] = (s1_c[j] | s2_c[j]) ? cur[j] : '0;
    end
  end

  arm_voltage_sum #(.N_SM(N_SM), .DW(DW)) u_sum (
    .vout_flat (vout_c),
    .vdc       (vdc),
    .is_lower  (arm_lower),
    .vnode     (vnode_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= '0;
      s2_q    <= '0;
      fault_q <= '0;
      vnode_q <= '0;
      icap_q  <= '0;
    end else if (step) begin
      s1_q    <= s1_c;
      s2_q    <= s2_c;
      fault_q <= fault_c;
      vnode_q <= vnode_c;
      icap_q  <= icap_c;
    end
  end

endmodule

// File: rtl/arm_switch_eval_chk.sv
module arm_switch_eval_chk #(
  parameter int N_SM = 4,
  parameter int DW   = 16,
  localparam int SW  = DW + $clog2(N_SM) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 step,
  input logic signed [DW-1:0] i_arm,
  input logic [2*N_SM-1:0]    gate,
  input logic [N_SM-1:0]      s1_q,
  input logic [N_SM-1:0]      s2_q,
  input logic [N_SM-1:0]      fault_q,
  input logic signed [SW-1:0] vnode_q,
  input logic [N_SM*DW-1:0]   icap_q
);

  logic seen_step;
  always_ff @(posedge clk) begin
    if (rst)       seen_step <= 1'b0;
    else if (step) seen_step <= 1'b1;
  end

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (s1_q == '0 && s2_q == '0 && fault_q == '0 && vnode_q == '0 && icap_q == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(vnode_q) && $stable(s1_q) && $stable(icap_q) && $stable(fault_q)));

  a_r10_complement: assert property (@(posedge clk) disable iff (rst)
    seen_step |-> ((s1_q ^ s2_q) == {N_SM{1'b1}}));

  for (genvar j = 0; j < N_SM; j++) begin : g_chk
    a_r1_force_s1: assert property (@(posedge clk) disable iff (rst)
      (step && gate[2*j +: 2] == 2'b01) |=> (s1_q[j] && !s2_q[j]));
    a_r2_force_s2: assert property (@(posedge clk) disable iff (rst)
      (step && gate[2*j +: 2] == 2'b10) |=> (!s1_q[j] && s2_q[j]));
    a_r3_blocked_dir: assert property (@(posedge clk) disable iff (rst)
      (step && gate[2*j +: 2] == 2'b00) |=> (s1_q[j] == !$past(i_arm[DW-1])));
    a_r4_shoot_flag: assert property (@(posedge clk) disable iff (rst)
      step |=> (fault_q[j] == ($past(gate[2*j +: 2]) == 2'b11)));
    a_r5_cap_current: assert property (@(posedge clk) disable iff (rst)
      step |=> (icap_q[j*DW +: DW] == (s1_q[j] ? $past(i_arm) : '0)));
  end

endmodule

bind arm_switch_eval arm_switch_eval_chk #(.N_SM(N_SM), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .step    (step),
  .i_arm   (i_arm),
  .gate    (gate),
  .s1_q    (s1_q),
  .s2_q    (s2_q),
  .fault_q (fault_q),
  .vnode_q (vnode_q),
  .icap_q  (icap_q)
);

// File: tb/arm_switch_eval_test.sv
module arm_switch_eval_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int SW = DW + $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step = 1'b0;
  logic arm_lower = 1'b0;
  logic signed [DW-1:0] i_arm = '0;
  logic signed [DW-1:0] vdc = '0;
  logic [N*DW-1:0] vcap = '0;
  logic [2*N-1:0] gate = '0;
  logic [N-1:0] s1_q, s2_q, fault_q;
  logic signed [SW-1:0] vnode_q;
  logic [N*DW-1:0] icap_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  arm_switch_eval #(.N_SM(N), .DW(DW)) uut (
    .clk(clk), .rst(rst), .step(step), .arm_lower(arm_lower), .i_arm(i_arm),
    .vdc(vdc), .vcap(vcap), .gate(gate), .s1_q(s1_q), .s2_q(s2_q),
    .fault_q(fault_q), .vnode_q(vnode_q), .icap_q(icap_q)
  );

  typedef struct {
    logic [N-1:0] s1, s2, flt;
    logic signed [SW-1:0] vn;
    logic [N*DW-1:0] ic;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;
  bit have_last = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input exp_t e, input string tag);
    chk(tag, "s1", s1_q, e.s1);
    chk(tag, "s2", s2_q, e.s2);
    chk(tag, "fault", fault_q, e.flt);
    chk(tag, "vnode", vnode_q, e.vn);
    for (int j = 0; j < N; j++)
      chk(tag, "icap", $signed(icap_q[j*DW +: DW]), $signed(e.ic[j*DW +: DW]));
    chk({tag, " R10"}, "s1^s2", s1_q ^ s2_q, {N{1'b1}});
  endtask

  function automatic exp_t model(input logic [2*N-1:0] g, input logic signed [DW-1:0] ia,
                                 input logic signed [DW-1:0] vd, input logic lw,
                                 input logic [N*DW-1:0] vc, input string tag);
    exp_t e;
    longint sum = 0;
    e.ic = '0;
    for (int j = 0; j < N; j++) begin
      logic g1, g2, on1;
      g1 = g[2*j];
      g2 = g[2*j+1];
      if (g1 && !g2)      on1 = 1'b1;
      else if (g2 && !g1) on1 = 1'b0;
      else                on1 = (ia >= 0);
      e.s1[j]  = on1;
      e.s2[j]  = !on1;
      e.flt[j] = g1 && g2;
      if (on1) begin
        sum += $signed(vc[j*DW +: DW]);
        e.ic[j*DW +: DW] = ia;
      end
    end
    e.vn  = lw ? SW'(longint'(vd) + sum) : SW'(longint'(vd) - sum);
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [N*DW-1:0] pack4(input int a, input int b, input int c, input int d);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  task automatic drive(input logic [2*N-1:0] g, input int ia, input int vd, input logic lw,
                       input logic [N*DW-1:0] vc, input string tag);
    @(negedge clk);
    gate = g; i_arm = DW'(ia); vdc = DW'(vd); arm_lower = lw; vcap = vc; step = 1'b1;
    sb.push_back(model(g, DW'(ia), DW'(vd), lw, vc, tag));
    @(negedge clk);
    step = 1'b0;
  endtask

  // Monitor: pops on step edges, checks hold (R8) otherwise
  initial begin
    forever begin
      logic st;
      @(posedge clk);
      st = step;
      #1;
      if (!rst && !done) begin
        if (st) begin
          if (sb.size() == 0) chk("R8", "unexpected step", 1, 0);
          else begin
            last = sb.pop_front();
            have_last = 1;
            compare(last, last.tag);
          end
        end else if (have_last) begin
          compare(last, "R8 hold");
        end
      end
    end
  end

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // Step during reset must not load anything
    step = 1'b1; gate = 8'b01010101; i_arm = 16'sd50; vcap = pack4(7, 7, 7, 7);
    repeat (3) @(negedge clk);
    rst = 1'b0; step = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9", "s1", s1_q, 0);
    chk("R9", "s2", s2_q, 0);
    chk("R9", "fault", fault_q, 0);
    chk("R9", "vnode", vnode_q, 0);
    chk("R9", "icap", icap_q, 0);

    // R1: S1 forced against negative current
    drive(8'b01010101, -300, 1000, 1'b0, pack4(100, 200, 300, 400), "R1");
    // R2: S2 forced against positive current
    drive(8'b10101010, 300, 1000, 1'b0, pack4(100, 200, 300, 400), "R2");
    // R3: blocked with zero, negative, positive current
    drive(8'b00000000, 0, 500, 1'b0, pack4(10, 20, 30, 40), "R3 zero");
    drive(8'b00000000, -1, 500, 1'b0, pack4(10, 20, 30, 40), "R3 neg");
    drive(8'b00000000, 1234, -500, 1'b1, pack4(10, 20, 30, 40), "R3 pos");
    // R4: shoot-through flagged and resolved as blocked
    drive(8'b11111111, -77, 0, 1'b0, pack4(5, 6, 7, 8), "R4 neg");
    drive(8'b11001011, 77, 0, 1'b0, pack4(5, 6, 7, 8), "R4 mixed");
    // R5: mixed gates, capacitor currents and inserted voltages
    drive(8'b00100110, -900, 2000, 1'b0, pack4(-150, 250, 350, 450), "R5");
    // R6: upper arm, full-scale sum
    drive(8'b01010101, 10, -32768, 1'b0, pack4(32767, 32767, 32767, 32767), "R6");
    // R7: lower arm, full-scale sum and negative voltages
    drive(8'b01010101, 10, -32768, 1'b1, pack4(32767, 32767, 32767, 32767), "R7 max");
    drive(8'b01010101, -5, 32767, 1'b1, pack4(-32768, -32768, -32768, -32768), "R7 min");

    // R8: inputs change without a step; outputs must hold
    @(negedge clk);
    gate = 8'b10101010; i_arm = -16'sd9; vdc = 16'sd1; arm_lower = 1'b0; vcap = pack4(1, 2, 3, 4);
    repeat (4) @(negedge clk);
    drive(8'b00000000, -20, 100, 1'b0, pack4(1, 2, 3, 4), "R8 after hold");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) chk("R8", "pending", sb.size(), 0);
    finish_run();
  end

endmodule